// File: doc/BRIEF.md
# Chained descriptor DMA engine

A single-channel DMA controller that follows a linked list of command descriptors held in memory. Each descriptor is a 32-byte record of four 64-bit words. Software builds the list, writes the high half of the chain pointer and then the low half. A non-zero pointer starts the engine.

For each descriptor, the engine reads all four words with one 4-beat burst. It copies them into its working registers and then asks an external data mover to transfer the loaded byte count between the local and remote addresses. When the mover finishes, the engine follows the link word to the next descriptor. A zero link ends the chain. Sticky status bits record each descriptor's completion, the whole chain's completion and the cause of any error. Each of these can raise its own interrupt line.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset, the configuration register (index 7) reads 1, with its channel-reset bit (bit 0) set. The status register (index 8) reads 0, no interrupt is asserted, and no memory request or mover start is issued.
- R2: While configuration bit 0 is set, the engine stays idle and ignores writes to the chain pointer (indices 0 low half, 1 high half). Setting the bit during a run returns the engine to idle, and no further completion is recorded.
- R3: Only a write to index 0 (the low 32 bits) whose resulting 64-bit pointer is non-zero starts the engine. A write to index 1 alone, or a low write that leaves the pointer at zero, does not start it.
- R4: A descriptor is fetched as one 4-beat read burst starting at the chain pointer. Beats 0..3 carry the next-link, local address, remote address and byte count. These load the working registers readable at indices 0/1, 2/3, 4/5 and 6.
- R5: The mover is started once per descriptor, only after that descriptor's four beats have arrived. It is given the loaded local address, remote address and count, plus the direction (configuration bit 1) and unit size (configuration bits 3:2).
- R6: When the mover reports done and the last link was non-zero, the engine fetches the next descriptor from that link address. Descriptors are therefore moved in list order.
- R7: A zero link does not overwrite the chain pointer. After the chain ends, the pointer reads back as the address of the final descriptor.
- R8: Status bit 5 is set each time a descriptor finishes without error. Status bit 6 is set when the descriptor with a zero link finishes.
- R9: Status bits 0..6 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: A mover error writes its 5-bit code into status bits 4:0 (a code of 0 is recorded as 0x1F) and aborts the chain. Neither bit 5 nor bit 6 is set.
- R11: A read error on a fetch beat records cause 0x10 in status bits 4:0 and aborts the chain without starting the mover.
- R12: Each interrupt output is the AND of one status bit and one enable bit. Descriptor-done uses status bit 5 with configuration bit 4. Chain-done uses status bit 6 with configuration bit 5. Error uses a non-zero status[4:0] with configuration bit 6. Status bit 7 reads 1 while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor burst read request |
| mem_addr | output | ADDR_W | Burst start address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |
| mem_rerr | input | 1 | Read beat error |
| mv_start | output | 1 | One-cycle transfer start |
| mv_local | output | ADDR_W | Local bus address |
| mv_remote | output | ADDR_W | Remote bus address |
| mv_count | output | CNT_W | Byte count |
| mv_dir | output | 1 | Transfer direction |
| mv_unit | output | 2 | Transfer unit size |
| mv_done | input | 1 | Transfer finished normally |
| mv_err | input | 1 | Transfer failed |
| mv_err_code | input | 5 | Failure cause |
| irq_desc | output | 1 | Descriptor-done interrupt |
| irq_chain | output | 1 | Chain-done interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench builds the engine with its default parameters: 64-bit addresses, a 64-bit read bus and a 32-bit count. Under these defaults, both halves of every pointer matter for the start decision. That lets the bench show that a high-half write alone never starts the engine. The 32-bit count lets the descriptor's count word be truncated and read back whole. The memory and mover models have adjustable latency and error injection on a chosen beat or descriptor. This covers mid-chain aborts, resets during a running transfer and the pointer value left behind by each kind of stop.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_START, SQ_RUN} seq_state_e;
  typedef enum logic [1:0] {FT_IDLE, FT_REQ, FT_BEAT} fetch_state_e;

  localparam int unsigned CAUSE_W  = 5;
  localparam int unsigned UNIT_W   = 2;
  localparam int unsigned CFG_W    = 7;
  localparam int unsigned STAT_W   = 7;
  localparam int unsigned FIELDS   = 4;
  localparam int unsigned FIELD_IW = $clog2(FIELDS);

  localparam logic [CAUSE_W-1:0] CAUSE_FETCH   = 5'h10;
  localparam logic [CAUSE_W-1:0] CAUSE_UNKNOWN = 5'h1F;

  localparam logic [3:0] RX_CHAIN_LO = 4'd0;
  localparam logic [3:0] RX_CHAIN_HI = 4'd1;
  localparam logic [3:0] RX_LOC_LO   = 4'd2;
  localparam logic [3:0] RX_LOC_HI   = 4'd3;
  localparam logic [3:0] RX_REM_LO   = 4'd4;
  localparam logic [3:0] RX_REM_HI   = 4'd5;
  localparam logic [3:0] RX_COUNT    = 4'd6;
  localparam logic [3:0] RX_CFG      = 4'd7;
  localparam logic [3:0] RX_STAT     = 4'd8;

  localparam int unsigned CF_RST      = 0;
  localparam int unsigned CF_DIR      = 1;
  localparam int unsigned CF_UNIT_LO  = 2;
  localparam int unsigned CF_IE_DESC  = 4;
  localparam int unsigned CF_IE_CHAIN = 5;
  localparam int unsigned CF_IE_ERR   = 6;

  localparam int unsigned ST_DESC  = 5;
  localparam int unsigned ST_CHAIN = 6;

  localparam logic [FIELD_IW-1:0] FLD_LINK   = 2'd0;
  localparam logic [FIELD_IW-1:0] FLD_LOCAL  = 2'd1;
  localparam logic [FIELD_IW-1:0] FLD_REMOTE = 2'd2;
  localparam logic [FIELD_IW-1:0] FLD_COUNT  = 2'd3;

  function automatic logic [63:0] put_half(input logic [63:0] old_v,
                                           input logic [31:0] w,
                                           input logic        hi);
    return hi ? {w, old_v[31:0]} : {old_v[63:32], w};
  endfunction

  function automatic logic [31:0] get_half(input logic [63:0] v, input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

  function automatic logic [CAUSE_W-1:0] mover_cause(input logic [CAUSE_W-1:0] c);
    return (c == '0) ? CAUSE_UNKNOWN : c;
  endfunction

endpackage

// File: rtl/cdma_fetch.sv
module cdma_fetch
  import cdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kill,
  input  logic                go,
  input  logic [ADDR_W-1:0]   base,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_gnt,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_rerr,
  output logic                ld_valid,
  output logic [FIELD_IW-1:0] ld_idx,
  output logic [DATA_W-1:0]   ld_data,
  output logic                done,
  output logic                err
);

  localparam logic [FIELD_IW-1:0] LAST_BEAT = FIELD_IW'(FIELDS - 1);

  fetch_state_e        st_q;
  logic [FIELD_IW-1:0] beat_q;
  logic                beat_in;

  assign beat_in  = (st_q == FT_BEAT) && mem_rvalid;
  assign mem_req  = (st_q == FT_REQ);
  assign mem_addr = base;
  assign ld_valid = beat_in && !mem_rerr;
  assign ld_idx   = beat_q;
  assign ld_data  = mem_rdata;
  assign done     = ld_valid && (beat_q == LAST_BEAT);
  assign err      = beat_in && mem_rerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FT_IDLE;
      beat_q <= '0;
    end else if (kill) begin
      st_q   <= FT_IDLE;
      beat_q <= '0;
    end else begin
      case (st_q)
        FT_IDLE: if (go) st_q <= FT_REQ;
        FT_REQ: begin
          if (mem_gnt) begin
            st_q   <= FT_BEAT;
            beat_q <= '0;
          end
        end
        FT_BEAT: begin
          if (err || done) st_q <= FT_IDLE;
          else if (ld_valid) beat_q <= beat_q + 1'b1;
        end
        default: st_q <= FT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic kick,
  input  logic fetch_done,
  input  logic fetch_err,
  input  logic link_zero,
  input  logic mv_done,
  input  logic mv_err,
  output logic fetch_go,
  output logic mv_start,
  output logic busy,
  output logic ev_desc,
  output logic ev_chain,
  output logic ev_err,
  output logic err_from_fetch
);

  seq_state_e st_q, st_d;

  assign busy = (st_q != SQ_IDLE);

  always_comb begin
    st_d           = st_q;
    fetch_go       = 1'b0;
    mv_start       = 1'b0;
    ev_desc        = 1'b0;
    ev_chain       = 1'b0;
    ev_err         = 1'b0;
    err_from_fetch = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (kick) begin
          fetch_go = 1'b1;
          st_d     = SQ_FETCH;
        end
      end
      SQ_FETCH: begin
        if (fetch_err) begin
          ev_err         = 1'b1;
          err_from_fetch = 1'b1;
          st_d           = SQ_IDLE;
        end else if (fetch_done) begin
          st_d = SQ_START;
        end
      end
      SQ_START: begin
        mv_start = 1'b1;
        st_d     = SQ_RUN;
      end
      SQ_RUN: begin
        if (mv_err) begin
          ev_err = 1'b1;
          st_d   = SQ_IDLE;
        end else if (mv_done) begin
          ev_desc = 1'b1;
          if (link_zero) begin
            ev_chain = 1'b1;
            st_d     = SQ_IDLE;
          end else begin
            fetch_go = 1'b1;
            st_d     = SQ_FETCH;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
    if (kill) begin
      st_d           = SQ_IDLE;
      fetch_go       = 1'b0;
      mv_start       = 1'b0;
      ev_desc        = 1'b0;
      ev_chain       = 1'b0;
      ev_err         = 1'b0;
      err_from_fetch = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [3:0]          reg_waddr,
  input  logic [31:0]         reg_wdata,
  input  logic [3:0]          reg_raddr,
  output logic [31:0]         reg_rdata,
  input  logic                busy,
  input  logic                ld_valid,
  input  logic [FIELD_IW-1:0] ld_idx,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic                ev_desc,
  input  logic                ev_chain,
  input  logic                ev_err,
  input  logic                err_from_fetch,
  input  logic [CAUSE_W-1:0]  mv_err_code,
  output logic [ADDR_W-1:0]   chain_q,
  output logic [ADDR_W-1:0]   local_q,
  output logic [ADDR_W-1:0]   remote_q,
  output logic [CNT_W-1:0]    count_q,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [STAT_W-1:0]   stat_q,
  output logic                link_zero_q,
  output logic                kick
);

  logic              chain_wr_ok;
  logic              idle_wr;
  logic [ADDR_W-1:0] chain_wr_val;
  logic [STAT_W-1:0] stat_clr;
  logic [STAT_W-1:0] stat_d;
  logic              link_nz;

  assign idle_wr      = reg_wr && !busy;
  assign chain_wr_ok  = idle_wr && !cfg_q[CF_RST] &&
                        ((reg_waddr == RX_CHAIN_LO) || (reg_waddr == RX_CHAIN_HI));
  assign chain_wr_val = ADDR_W'(put_half(64'(chain_q), reg_wdata, reg_waddr[0]));
  assign kick         = chain_wr_ok && (reg_waddr == RX_CHAIN_LO) && (chain_wr_val != '0);
  assign link_nz      = (ld_data != '0);
  assign stat_clr     = (reg_wr && reg_waddr == RX_STAT) ? reg_wdata[STAT_W-1:0] : '0;

  always_comb begin
    stat_d = stat_q & ~stat_clr;
    if (ev_desc)  stat_d[ST_DESC]  = 1'b1;
    if (ev_chain) stat_d[ST_CHAIN] = 1'b1;
    if (ev_err)   stat_d[CAUSE_W-1:0] = err_from_fetch ? CAUSE_FETCH : mover_cause(mv_err_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q     <= '0;
      local_q     <= '0;
      remote_q    <= '0;
      count_q     <= '0;
      cfg_q       <= CFG_W'(1);
      stat_q      <= '0;
      link_zero_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (reg_wr && reg_waddr == RX_CFG) cfg_q <= reg_wdata[CFG_W-1:0];

      if (chain_wr_ok)
        chain_q <= chain_wr_val;
      else if (ld_valid && ld_idx == FLD_LINK && link_nz)
        chain_q <= ADDR_W'(ld_data);

      if (ld_valid && ld_idx == FLD_LINK) link_zero_q <= !link_nz;

      if (idle_wr && (reg_waddr == RX_LOC_LO || reg_waddr == RX_LOC_HI))
        local_q <= ADDR_W'(put_half(64'(local_q), reg_wdata, reg_waddr[0]));
      else if (ld_valid && ld_idx == FLD_LOCAL)
        local_q <= ADDR_W'(ld_data);

      if (idle_wr && (reg_waddr == RX_REM_LO || reg_waddr == RX_REM_HI))
        remote_q <= ADDR_W'(put_half(64'(remote_q), reg_wdata, reg_waddr[0]));
      else if (ld_valid && ld_idx == FLD_REMOTE)
        remote_q <= ADDR_W'(ld_data);

      if (idle_wr && reg_waddr == RX_COUNT)
        count_q <= CNT_W'(reg_wdata);
      else if (ld_valid && ld_idx == FLD_COUNT)
        count_q <= CNT_W'(ld_data);
    end
  end

  always_comb begin
    case (reg_raddr)
      RX_CHAIN_LO: reg_rdata = get_half(64'(chain_q), 1'b0);
      RX_CHAIN_HI: reg_rdata = get_half(64'(chain_q), 1'b1);
      RX_LOC_LO:   reg_rdata = get_half(64'(local_q), 1'b0);
      RX_LOC_HI:   reg_rdata = get_half(64'(local_q), 1'b1);
      RX_REM_LO:   reg_rdata = get_half(64'(remote_q), 1'b0);
      RX_REM_HI:   reg_rdata = get_half(64'(remote_q), 1'b1);
      RX_COUNT:    reg_rdata = get_half(64'(count_q), 1'b0);
      RX_CFG:      reg_rdata = 32'(cfg_q);
      RX_STAT:     reg_rdata = {24'd0, busy, stat_q};
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import cdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_waddr,
  input  logic [31:0]        reg_wdata,
  input  logic [3:0]         reg_raddr,
  output logic [31:0]        reg_rdata,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_rerr,
  output logic               mv_start,
  output logic [ADDR_W-1:0]  mv_local,
  output logic [ADDR_W-1:0]  mv_remote,
  output logic [CNT_W-1:0]   mv_count,
  output logic               mv_dir,
  output logic [1:0]         mv_unit,
  input  logic               mv_done,
  input  logic               mv_err,
  input  logic [4:0]         mv_err_code,
  output logic               irq_desc,
  output logic               irq_chain,
  output logic               irq_err
);

  logic [ADDR_W-1:0]   chain_q;
  logic [ADDR_W-1:0]   local_q;
  logic [ADDR_W-1:0]   remote_q;
  logic [CNT_W-1:0]    count_q;
  logic [CFG_W-1:0]    cfg_q;
  logic [STAT_W-1:0]   stat_q;
  logic                link_zero_q;
  logic                kick;
  logic                chan_rst;
  logic                busy;
  logic                fetch_go;
  logic                fetch_done;
  logic                fetch_err;
  logic                ld_valid;
  logic [FIELD_IW-1:0] ld_idx;
  logic [DATA_W-1:0]   ld_data;
  logic                ev_desc;
  logic                ev_chain;
  logic                ev_err;
  logic                err_from_fetch;
  logic                desc_flag;

  assign chan_rst  = cfg_q[CF_RST];
  assign desc_flag = stat_q[ST_DESC];

  cdma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_waddr      (reg_waddr),
    .reg_wdata      (reg_wdata),
    .reg_raddr      (reg_raddr),
    .reg_rdata      (reg_rdata),
    .busy           (busy),
    .ld_valid       (ld_valid),
    .ld_idx         (ld_idx),
    .ld_data        (ld_data),
    .ev_desc        (ev_desc),
    .ev_chain       (ev_chain),
    .ev_err         (ev_err),
    .err_from_fetch (err_from_fetch),
    .mv_err_code    (mv_err_code),
    .chain_q        (chain_q),
    .local_q        (local_q),
    .remote_q       (remote_q),
    .count_q        (count_q),
    .cfg_q          (cfg_q),
    .stat_q         (stat_q),
    .link_zero_q    (link_zero_q),
    .kick           (kick)
  );

  cdma_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill       (chan_rst),
    .go         (fetch_go),
    .base       (chain_q),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_rerr   (mem_rerr),
    .ld_valid   (ld_valid),
    .ld_idx     (ld_idx),
    .ld_data    (ld_data),
    .done       (fetch_done),
    .err        (fetch_err)
  );

  cdma_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .kill           (chan_rst),
    .kick           (kick),
    .fetch_done     (fetch_done),
    .fetch_err      (fetch_err),
    .link_zero      (link_zero_q),
    .mv_done        (mv_done),
    .mv_err         (mv_err),
    .fetch_go       (fetch_go),
    .mv_start       (mv_start),
    .busy           (busy),
    .ev_desc        (ev_desc),
    .ev_chain       (ev_chain),
    .ev_err         (ev_err),
    .err_from_fetch (err_from_fetch)
  );

  assign mv_local  = local_q;
  assign mv_remote = remote_q;
  assign mv_count  = count_q;
  assign mv_dir    = cfg_q[CF_DIR];
  assign mv_unit   = cfg_q[CF_UNIT_LO +: UNIT_W];

  assign irq_desc  = stat_q[ST_DESC]  && cfg_q[CF_IE_DESC];
  assign irq_chain = stat_q[ST_CHAIN] && cfg_q[CF_IE_CHAIN];
  assign irq_err   = (stat_q[CAUSE_W-1:0] != '0) && cfg_q[CF_IE_ERR];

endmodule

// File: rtl/cdma_checker.sv
module cdma_checker #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_rst,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mv_start,
  input logic              fetch_done,
  input logic              ev_desc,
  input logic              ev_err,
  input logic              desc_flag,
  input logic [ADDR_W-1:0] chain_q
);

  p_kill_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !busy);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  p_idle_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_start_after_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |-> $past(fetch_done));

  p_single_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

  p_chain_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chain_q != '0));

  p_desc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc |=> desc_flag);

  p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_err && ev_desc));

endmodule

bind chain_dma_engine cdma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_rst   (chan_rst),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .mv_start   (mv_start),
  .fetch_done (fetch_done),
  .ev_desc    (ev_desc),
  .ev_err     (ev_err),
  .desc_flag  (desc_flag),
  .chain_q    (chain_q)
);

// File: tb/chain_dma_engine_bench.sv
module chain_dma_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 32;
  localparam logic [63:0] MEM_BASE = 64'h1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [3:0]        reg_waddr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [3:0]        reg_raddr = '0;
  logic [31:0]       reg_rdata;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_gnt = 1'b0;
  logic              mem_rvalid = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              mem_rerr = 1'b0;
  logic              mv_start;
  logic [ADDR_W-1:0] mv_local;
  logic [ADDR_W-1:0] mv_remote;
  logic [CNT_W-1:0]  mv_count;
  logic              mv_dir;
  logic [1:0]        mv_unit;
  logic              mv_done = 1'b0;
  logic              mv_err = 1'b0;
  logic [4:0]        mv_err_code = '0;
  logic              irq_desc, irq_chain, irq_err;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] dmem [0:15];
  int fetch_err_beat = -1;
  int mem_grants = 0;
  int mv_n = 0;
  int mv_lat = 3;
  int mv_fail_at = -1;
  logic [4:0] mv_fail_code = '0;
  logic [63:0] log_loc [0:7];
  logic [63:0] log_rem [0:7];
  logic [31:0] log_cnt [0:7];
  logic        log_dir [0:7];
  logic [1:0]  log_unit [0:7];

  chain_dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chain_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .mv_start(mv_start), .mv_local(mv_local), .mv_remote(mv_remote), .mv_count(mv_count),
    .mv_dir(mv_dir), .mv_unit(mv_unit), .mv_done(mv_done), .mv_err(mv_err),
    .mv_err_code(mv_err_code), .irq_desc(irq_desc), .irq_chain(irq_chain), .irq_err(irq_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    logic [63:0] off = (a - MEM_BASE) >> 3;
    if (a < MEM_BASE || off > 64'd15) return 64'd0;
    return dmem[off[3:0]];
  endfunction

  // memory burst model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [63:0] a;
        a = mem_addr;
        mem_gnt = 1'b1;
        mem_grants++;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int b = 0; b < 4; b++) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(a + 64'(8 * b));
          mem_rerr   = (b == fetch_err_beat);
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
        mem_rerr   = 1'b0;
      end
    end
  end

  // data mover model
  initial begin
    forever begin
      @(negedge clk);
      if (mv_start) begin
        int idx;
        idx = mv_n;
        if (idx < 8) begin
          log_loc[idx] = mv_local; log_rem[idx] = mv_remote; log_cnt[idx] = mv_count;
          log_dir[idx] = mv_dir;   log_unit[idx] = mv_unit;
        end
        mv_n++;
        repeat (mv_lat) @(negedge clk);
        if (idx == mv_fail_at) begin mv_err = 1'b1; mv_err_code = mv_fail_code; end
        else mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0; mv_err = 1'b0; mv_err_code = '0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = idx;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd64(input logic [3:0] lo_idx, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(lo_idx, lo);
    rd(lo_idx + 4'd1, hi);
    d = {hi, lo};
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(4'd8, s);
      if (!s[7]) return;
    end
  endtask

  task automatic set_desc(input int i, input logic [63:0] link, input logic [63:0] loc,
                          input logic [63:0] rem, input logic [63:0] cnt);
    dmem[i*4+0] = link; dmem[i*4+1] = loc; dmem[i*4+2] = rem; dmem[i*4+3] = cnt;
  endtask

  task automatic launch(input logic [63:0] a);
    wr(4'd1, a[63:32]);
    wr(4'd0, a[31:0]);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd7, d); chk_eq("R1 config reset", 64'(d), 64'h1);
    rd(4'd8, d); chk_eq("R1 status reset", 64'(d), 64'h0);
    chk_eq("R1 irqs low", {61'd0, irq_desc, irq_chain, irq_err}, 64'd0);
    chk_eq("R1 no mem req", 64'(mem_req), 64'd0);
  endtask

  task automatic t_rst_ignores();
    logic [63:0] c;
    launch(MEM_BASE);
    repeat (10) @(negedge clk);
    chk_eq("R2 no fetch while channel reset", 64'(mem_grants), 64'd0);
    rd64(4'd0, c);
    chk_eq("R2 chain write ignored", c, 64'd0);
    wr(4'd7, 32'h0);
  endtask

  task automatic t_no_start();
    wr(4'd1, 32'h5);
    repeat (8) @(negedge clk);
    chk_eq("R3 high half alone no start", 64'(mem_grants), 64'd0);
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h0);
    repeat (8) @(negedge clk);
    chk_eq("R3 zero pointer no start", 64'(mem_grants + mv_n), 64'd0);
  endtask

  task automatic t_single();
    logic [31:0] s;
    logic [63:0] v;
    set_desc(0, 64'h0, 64'hAAAA_0000_0000_1111, 64'hBBBB_0000_0000_2222, 64'hFFFF_0000_0000_0040);
    wr(4'd7, 32'h0000_000E);
    launch(MEM_BASE);
    wait_idle();
    chk_eq("R4 one burst", 64'(mem_grants), 64'd1);
    chk_eq("R5 one mover start", 64'(mv_n), 64'd1);
    chk_eq("R5 mover local", log_loc[0], 64'hAAAA_0000_0000_1111);
    chk_eq("R5 mover remote", log_rem[0], 64'hBBBB_0000_0000_2222);
    chk_eq("R5 mover count", 64'(log_cnt[0]), 64'h40);
    chk_eq("R5 dir and unit", {61'd0, log_dir[0], log_unit[0]}, 64'b111);
    rd64(4'd2, v); chk_eq("R4 local readback", v, 64'hAAAA_0000_0000_1111);
    rd64(4'd4, v); chk_eq("R4 remote readback", v, 64'hBBBB_0000_0000_2222);
    rd(4'd6, s);   chk_eq("R4 count readback", 64'(s), 64'h40);
    rd64(4'd0, v); chk_eq("R7 pointer kept", v, MEM_BASE);
    rd(4'd8, s);   chk_eq("R8 desc and chain bits", 64'(s), 64'h60);
    chk_eq("R12 irqs masked", {61'd0, irq_desc, irq_chain, irq_err}, 64'd0);
    wr(4'd8, 32'h7F);
  endtask

  task automatic t_chain3();
    logic [31:0] s;
    logic [63:0] v;
    set_desc(1, MEM_BASE + 64'h40, 64'h100, 64'h200, 64'h10);
    set_desc(2, MEM_BASE + 64'h60, 64'h110, 64'h210, 64'h20);
    set_desc(3, 64'h0,             64'h120, 64'h220, 64'h30);
    wr(4'd7, 32'h0000_0030);
    mv_n = 0; mem_grants = 0;
    launch(MEM_BASE + 64'h20);
    wait_idle();
    chk_eq("R6 three descriptors", 64'(mv_n), 64'd3);
    chk_eq("R6 order 0", log_loc[0], 64'h100);
    chk_eq("R6 order 1", log_loc[1], 64'h110);
    chk_eq("R6 order 2", {log_loc[2][31:0], log_cnt[2]}, {32'h120, 32'h30});
    rd64(4'd0, v); chk_eq("R7 pointer is final descriptor", v, MEM_BASE + 64'h60);
    rd(4'd8, s);   chk_eq("R8 status after chain", 64'(s), 64'h60);
    chk_eq("R12 desc and chain irqs", {62'd0, irq_desc, irq_chain}, 64'b11);
    wr(4'd8, 32'h20);
    rd(4'd8, s);   chk_eq("R9 clear desc only", 64'(s), 64'h40);
    chk_eq("R12 desc irq dropped", {62'd0, irq_desc, irq_chain}, 64'b01);
    wr(4'd8, 32'h0);
    rd(4'd8, s);   chk_eq("R9 zero write keeps", 64'(s), 64'h40);
    wr(4'd8, 32'h40);
    rd(4'd8, s);   chk_eq("R9 all clear", 64'(s), 64'h0);
  endtask

  task automatic t_mv_err();
    logic [31:0] s;
    wr(4'd7, 32'h0000_0040);
    mv_n = 0; mv_fail_at = 0; mv_fail_code = 5'h0A;
    launch(MEM_BASE + 64'h20);
    wait_idle();
    chk_eq("R10 chain aborted", 64'(mv_n), 64'd1);
    rd(4'd8, s); chk_eq("R10 cause recorded", 64'(s), 64'h0A);
    chk_eq("R12 error irq", 64'(irq_err), 64'd1);
    wr(4'd8, 32'h7F);
    mv_n = 0; mv_fail_at = 0; mv_fail_code = 5'h0;
    launch(MEM_BASE + 64'h60);
    wait_idle();
    rd(4'd8, s); chk_eq("R10 zero code as 0x1F", 64'(s), 64'h1F);
    wr(4'd8, 32'h7F);
    mv_fail_at = -1;
  endtask

  task automatic t_fetch_err();
    logic [31:0] s;
    mv_n = 0; mem_grants = 0; fetch_err_beat = 2;
    launch(MEM_BASE + 64'h20);
    wait_idle();
    repeat (6) @(negedge clk);
    chk_eq("R11 mover never started", 64'(mv_n), 64'd0);
    rd(4'd8, s); chk_eq("R11 fetch cause", 64'(s), 64'h10);
    fetch_err_beat = -1;
    wr(4'd8, 32'h7F);
  endtask

  task automatic t_kill();
    logic [31:0] s;
    wr(4'd7, 32'h0);
    mv_n = 0; mv_lat = 30;
    launch(MEM_BASE + 64'h20);
    for (int i = 0; i < 200 && mv_n == 0; i++) @(negedge clk);
    wr(4'd7, 32'h1);
    rd(4'd8, s); chk_eq("R2 idle after channel reset", 64'(s[7]), 64'd0);
    repeat (50) @(negedge clk);
    rd(4'd8, s); chk_eq("R2 no completion after kill", 64'(s), 64'h0);
    chk_eq("R2 no further descriptors", 64'(mv_n), 64'd1);
    mv_lat = 3;
    wr(4'd7, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rst_ignores();
    t_no_start();
    t_single();
    t_chain3();
    t_mv_err();
    t_fetch_err();
    t_kill();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule